// File: doc/BRIEF.md
# Physical Request Admission Controller

This block sits between the receive side of a serial-bus link and a memory-access engine. Each decoded asynchronous request carries a kind, a source node, an address offset, a transaction tag and a speed code. The block decides whether the request is serviced directly against memory. It returns one acknowledge code for every accepted request. Requests that it admits go into a small in-order pending queue, and the queue feeds a memory-request port that has a single completion/error return.

Posted writes are acknowledged as complete at once, before memory has taken the data. An error reported later for such a write is signalled by an interrupt pulse and a sticky status bit. Reads, locks and non-posted writes are acknowledged as pending. A bus reset throws away every pending entry that has not yet been issued. The bus reset also drops the filter-ready state. From then on only accesses to the autonomous CSR window are admitted, until software writes the per-source enable mask again.

Top module: `phys_req_admit`

## Requirements
- R1: While `busReset` is high, `reqReady` is low and no request is accepted.
- R2: An admitted posted write (`reqType` = 1) is acknowledged one cycle after acceptance with `ackCode` 0 (complete) and is queued.
- R3: An admitted read (`reqType` 0), non-posted write (`reqType` 2) or lock (`reqType` 3) is acknowledged with `ackCode` 1 (pending) and is queued.
- R4: A request that would be admitted while the queue holds DEPTH entries (default 4) is acknowledged with `ackCode` 2 (busy) and is not queued.
- R5: While the filter-ready flag is clear, a request whose offset lies outside the CSR window [CSR_BASE, CSR_BASE+CSR_SIZE) gets `ackCode` 2 and is not queued. Requests inside the window are still admitted.
- R6: A `filterWrEn` strobe loads the enable mask and sets the filter-ready flag. A non-CSR request whose source bit in the mask is 0 then gets `ackCode` 3 (left to the software path) and is not queued.
- R7: A bus reset marks every queued non-posted entry as discarded, and such an entry never appears on the memory port. Queued posted writes are still issued.
- R8: Queued entries are issued on the memory port in acceptance order, with their fields unchanged. `memValid` stays low while an access is outstanding, that is, from an issue until the next `memDoneValid`.
- R9: A completion with `memDoneErr` for an outstanding posted write produces a one-cycle `intrPulse` in the next cycle and sets `intrStatus`.
- R10: A completion of a read, lock or non-posted write never raises `intrPulse` or sets `intrStatus`, even when it carries an error.
- R11: `intrClr` clears `intrStatus`. A new error event in the same cycle takes priority.
- R12: After reset, `ackValid`, `memValid`, `intrPulse` and `intrStatus` are 0 and the filter-ready flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReset | input | 1 | Serial-bus reset indication |
| reqValid | input | 1 | Request descriptor valid |
| reqReady | output | 1 | Request can be accepted |
| reqType | input | 2 | 0 read, 1 posted write, 2 non-posted write, 3 lock |
| reqSrc | input | NODE_W | Source node ID |
| reqOffset | input | OFFS_W | Target address offset |
| reqTag | input | TAG_W | Transaction tag |
| reqSpeed | input | SPD_W | Received speed code |
| ackValid | output | 1 | Acknowledge code valid |
| ackCode | output | 2 | 0 complete, 1 pending, 2 busy, 3 software path |
| filterWrEn | input | 1 | Software write of the enable mask |
| filterWrData | input | 2**NODE_W | Per-source enable mask |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory engine takes the request |
| memType | output | 2 | Request kind |
| memSrc | output | NODE_W | Source node ID |
| memOffset | output | OFFS_W | Address offset |
| memTag | output | TAG_W | Transaction tag |
| memSpeed | output | SPD_W | Speed code |
| memDoneValid | input | 1 | Outstanding access finished |
| memDoneErr | input | 1 | Finished access failed |
| intrPulse | output | 1 | Posted-write error event |
| intrStatus | output | 1 | Sticky posted-write error flag |
| intrClr | input | 1 | Clears the sticky flag |

## Verification
The checker assumes that every `memDoneValid` answers exactly one earlier issue on the memory port. On that basis it tracks the kind of the access in flight and can tell posted-write completions from others. It also treats `intrClr`, `busReset` and `filterWrEn` as level inputs sampled on every edge, with no handshake. The bench raises a completion only while its own reference model says an access is in flight. It drives every input at the falling edge, so each rising edge sees a stable request, reset or clear, including cases where a bus reset coincides with a presented request.

// File: rtl/phys_adm_pkg.sv
`timescale 1ns/1ps
package phys_adm_pkg;

  typedef enum logic [1:0] {
    REQ_READ      = 2'd0,
    REQ_WR_POSTED = 2'd1,
    REQ_WR_FULL   = 2'd2,
    REQ_LOCK      = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    ACK_DONE  = 2'd0,
    ACK_PEND  = 2'd1,
    ACK_BUSY  = 2'd2,
    ACK_ROUTE = 2'd3
  } ackKind_e;

  // strobes from control to the queue datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic killPend;
  } qStrobe_t;

endpackage

// File: rtl/phys_adm_dpath.sv
`timescale 1ns/1ps
module phys_adm_dpath
  import phys_adm_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strobe,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pushPosted,
  output logic [DATA_W-1:0] headData,
  output logic              headPosted,
  output logic              headKilled,
  output logic              headValid,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] slotData   [DEPTH];
  logic              slotPosted [DEPTH];
  logic              slotKilled [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // per-slot storage; a bus reset tags only non-posted slots (R7)
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData[g]   <= '0;
        slotPosted[g] <= 1'b0;
        slotKilled[g] <= 1'b0;
      end else if (strobe.push && wrPtr == PTR_W'(g)) begin
        slotData[g]   <= pushData;
        slotPosted[g] <= pushPosted;
        slotKilled[g] <= 1'b0;
      end else if (strobe.killPend && !slotPosted[g]) begin
        slotKilled[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headValid  = (count != '0);
  assign full       = (count == CNT_W'(DEPTH));
  assign headData   = slotData[rdPtr];
  assign headPosted = slotPosted[rdPtr];
  assign headKilled = slotKilled[rdPtr];

endmodule

// File: rtl/phys_adm_ctrl.sv
`timescale 1ns/1ps
module phys_adm_ctrl
  import phys_adm_pkg::*;
#(
  parameter int              NODE_W   = 6,
  parameter int              OFFS_W   = 16,
  parameter logic [OFFS_W-1:0] CSR_BASE = 16'hF000,
  parameter logic [OFFS_W-1:0] CSR_SIZE = 16'h0400
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busReset,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [1:0]             reqType,
  input  logic [NODE_W-1:0]      reqSrc,
  input  logic [OFFS_W-1:0]      reqOffset,
  output logic                   ackValid,
  output logic [1:0]             ackCode,
  input  logic                   filterWrEn,
  input  logic [(1<<NODE_W)-1:0] filterWrData,
  input  logic                   headValid,
  input  logic                   headKilled,
  input  logic                   headPosted,
  input  logic                   full,
  output qStrobe_t               strobe,
  output logic                   pushPosted,
  output logic                   memValid,
  input  logic                   memReady,
  input  logic                   memDoneValid,
  input  logic                   memDoneErr,
  output logic                   intrPulse,
  output logic                   intrStatus,
  input  logic                   intrClr
);
  localparam int NODES = 1 << NODE_W;
  localparam logic [OFFS_W:0] CSR_END = {1'b0, CSR_BASE} + {1'b0, CSR_SIZE};

  logic             filtReady;
  logic [NODES-1:0] srcMask;
  logic             outBusy, outPosted;
  logic             accept, inCsr, isPosted, physGo, issue;
  ackKind_e         decision;

  assign reqReady = !busReset;                         // R1
  assign accept   = reqValid && reqReady;
  assign inCsr    = ({1'b0, reqOffset} >= {1'b0, CSR_BASE}) &&
                    ({1'b0, reqOffset} <  CSR_END);
  assign isPosted = (reqKind_e'(reqType) == REQ_WR_POSTED);

  always_comb begin
    if (!inCsr && !filtReady)         decision = ACK_BUSY;   // R5
    else if (!inCsr && !srcMask[reqSrc]) decision = ACK_ROUTE; // R6
    else if (full)                    decision = ACK_BUSY;   // R4
    else if (isPosted)                decision = ACK_DONE;   // R2
    else                              decision = ACK_PEND;   // R3
  end

  assign physGo     = (decision == ACK_DONE) || (decision == ACK_PEND);
  assign pushPosted = isPosted;

  // R8: one access in flight; no issue during a bus reset
  assign memValid = headValid && !headKilled && !outBusy && !busReset;
  assign issue    = memValid && memReady;

  always_comb begin
    strobe.push     = accept && physGo;
    strobe.pop      = issue || (headValid && headKilled);  // R7 discard
    strobe.killPend = busReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtReady <= 1'b0;
      srcMask   <= '0;
    end else if (busReset) begin
      filtReady <= 1'b0;
    end else if (filterWrEn) begin
      filtReady <= 1'b1;
      srcMask   <= filterWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackCode  <= ACK_DONE;
    end else begin
      ackValid <= accept;
      ackCode  <= decision;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBusy   <= 1'b0;
      outPosted <= 1'b0;
    end else if (issue) begin
      outBusy   <= 1'b1;
      outPosted <= headPosted;
    end else if (memDoneValid) begin
      outBusy   <= 1'b0;
    end
  end

  // R9/R10/R11
  logic errEvent;
  assign errEvent = memDoneValid && memDoneErr && outBusy && outPosted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intrPulse  <= 1'b0;
      intrStatus <= 1'b0;
    end else begin
      intrPulse  <= errEvent;
      intrStatus <= (intrStatus && !intrClr) || errEvent;
    end
  end

endmodule

// File: rtl/phys_req_admit.sv
`timescale 1ns/1ps
module phys_req_admit
  import phys_adm_pkg::*;
#(
  parameter int              NODE_W   = 6,
  parameter int              OFFS_W   = 16,
  parameter int              TAG_W    = 6,
  parameter int              SPD_W    = 2,
  parameter int              DEPTH    = 4,
  parameter logic [OFFS_W-1:0] CSR_BASE = 16'hF000,
  parameter logic [OFFS_W-1:0] CSR_SIZE = 16'h0400
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busReset,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [1:0]             reqType,
  input  logic [NODE_W-1:0]      reqSrc,
  input  logic [OFFS_W-1:0]      reqOffset,
  input  logic [TAG_W-1:0]       reqTag,
  input  logic [SPD_W-1:0]       reqSpeed,
  output logic                   ackValid,
  output logic [1:0]             ackCode,
  input  logic                   filterWrEn,
  input  logic [(1<<NODE_W)-1:0] filterWrData,
  output logic                   memValid,
  input  logic                   memReady,
  output logic [1:0]             memType,
  output logic [NODE_W-1:0]      memSrc,
  output logic [OFFS_W-1:0]      memOffset,
  output logic [TAG_W-1:0]       memTag,
  output logic [SPD_W-1:0]       memSpeed,
  input  logic                   memDoneValid,
  input  logic                   memDoneErr,
  output logic                   intrPulse,
  output logic                   intrStatus,
  input  logic                   intrClr
);
  localparam int DATA_W = 2 + NODE_W + OFFS_W + TAG_W + SPD_W;

  qStrobe_t          strobe;
  logic [DATA_W-1:0] pushData, headData;
  logic              pushPosted, headPosted, headKilled, headValid, full;

  assign pushData = {reqType, reqSrc, reqOffset, reqTag, reqSpeed};
  assign {memType, memSrc, memOffset, memTag, memSpeed} = headData;

  phys_adm_ctrl #(
    .NODE_W(NODE_W), .OFFS_W(OFFS_W), .CSR_BASE(CSR_BASE), .CSR_SIZE(CSR_SIZE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset),
    .reqValid(reqValid), .reqReady(reqReady), .reqType(reqType),
    .reqSrc(reqSrc), .reqOffset(reqOffset),
    .ackValid(ackValid), .ackCode(ackCode),
    .filterWrEn(filterWrEn), .filterWrData(filterWrData),
    .headValid(headValid), .headKilled(headKilled), .headPosted(headPosted),
    .full(full), .strobe(strobe), .pushPosted(pushPosted),
    .memValid(memValid), .memReady(memReady),
    .memDoneValid(memDoneValid), .memDoneErr(memDoneErr),
    .intrPulse(intrPulse), .intrStatus(intrStatus), .intrClr(intrClr)
  );

  phys_adm_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pushData(pushData), .pushPosted(pushPosted),
    .headData(headData), .headPosted(headPosted), .headKilled(headKilled),
    .headValid(headValid), .full(full)
  );

endmodule

// File: rtl/phys_adm_chk.sv
`timescale 1ns/1ps
module phys_adm_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busReset,
  input logic       reqValid,
  input logic       reqReady,
  input logic       ackValid,
  input logic       memValid,
  input logic       memReady,
  input logic [1:0] memType,
  input logic       memDoneValid,
  input logic       intrPulse,
  input logic       intrStatus,
  input logic       intrClr
);
  logic seen, chkOut, chkOutPosted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen         <= 1'b0;
      chkOut       <= 1'b0;
      chkOutPosted <= 1'b0;
    end else begin
      seen <= 1'b1;
      if (memValid && memReady) begin
        chkOut       <= 1'b1;
        chkOutPosted <= (memType == 2'd1);
      end else if (memDoneValid) begin
        chkOut <= 1'b0;
      end
    end
  end

  p_ready_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    busReset |-> !reqReady);

  p_ack_follows_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seen && ackValid) |-> $past(reqValid && reqReady));

  p_no_issue_in_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    busReset |-> !memValid);

  p_single_outstanding_r8: assert property (@(posedge clk) disable iff (!rstN)
    chkOut |-> !memValid);

  p_intr_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    intrPulse |=> !intrPulse);

  p_intr_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    intrPulse |-> intrStatus);

  p_no_plain_intr_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memDoneValid && chkOut && !chkOutPosted) |=> !intrPulse);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (seen && $past(intrClr) && !intrPulse) |-> !intrStatus);

endmodule

bind phys_req_admit phys_adm_chk u_chk (
  .clk(clk), .rstN(rstN), .busReset(busReset), .reqValid(reqValid),
  .reqReady(reqReady), .ackValid(ackValid), .memValid(memValid),
  .memReady(memReady), .memType(memType), .memDoneValid(memDoneValid),
  .intrPulse(intrPulse), .intrStatus(intrStatus), .intrClr(intrClr)
);

// File: tb/phys_req_admit_bench.sv
`timescale 1ns/1ps
module phys_req_admit_bench;
  localparam int DEPTH = 4;
  localparam logic [15:0] CSR_BASE = 16'hF000;
  localparam logic [15:0] CSR_SIZE = 16'h0400;

  logic clk = 0, rstN = 0;
  logic busReset = 0, reqValid = 0, filterWrEn = 0, memReady = 0;
  logic memDoneValid = 0, memDoneErr = 0, intrClr = 0;
  logic [1:0] reqType = 0;
  logic [5:0] reqSrc = 0, reqTag = 0;
  logic [15:0] reqOffset = 0;
  logic [1:0] reqSpeed = 0;
  logic [63:0] filterWrData = 0;
  wire reqReady, ackValid, memValid, intrPulse, intrStatus;
  wire [1:0] ackCode, memType, memSpeed;
  wire [5:0] memSrc, memTag;
  wire [15:0] memOffset;

  always #2.5 clk = ~clk;

  phys_req_admit u_phys_req_admit (
    .clk(clk), .rstN(rstN), .busReset(busReset), .reqValid(reqValid),
    .reqReady(reqReady), .reqType(reqType), .reqSrc(reqSrc),
    .reqOffset(reqOffset), .reqTag(reqTag), .reqSpeed(reqSpeed),
    .ackValid(ackValid), .ackCode(ackCode), .filterWrEn(filterWrEn),
    .filterWrData(filterWrData), .memValid(memValid), .memReady(memReady),
    .memType(memType), .memSrc(memSrc), .memOffset(memOffset),
    .memTag(memTag), .memSpeed(memSpeed), .memDoneValid(memDoneValid),
    .memDoneErr(memDoneErr), .intrPulse(intrPulse), .intrStatus(intrStatus),
    .intrClr(intrClr)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] qBody [DEPTH];
  bit qPost [DEPTH], qKill [DEPTH];
  int mCnt = 0;
  bit mOut = 0, mOutPosted = 0, mInit = 0;
  logic [63:0] mMask = 0;
  bit expAckValid = 0, expPulse = 0, expStatus = 0;
  logic [1:0] expAckCode = 0;
  string expAckTag = "R2", expIntrTag = "R9";

  function automatic logic [1:0] decide(input logic [1:0] t, input logic [5:0] s,
                                        input logic [15:0] o, output string tag);
    bit csr = (o >= CSR_BASE) && ({1'b0, o} < {1'b0, CSR_BASE} + {1'b0, CSR_SIZE});
    if (!csr && !mInit)      begin tag = "R5"; return 2'd2; end
    if (!csr && !mMask[s])   begin tag = "R6"; return 2'd3; end
    if (mCnt == DEPTH)       begin tag = "R4"; return 2'd2; end
    tag = (!mInit) ? "R5" : ((t == 2'd1) ? "R2" : "R3");
    return (t == 2'd1) ? 2'd0 : 2'd1;
  endfunction

  always @(posedge clk) begin : mdl
    bit hv, mmv, iss, pk, acc, pulse;
    logic [1:0] code;
    string tag;
    if (!rstN) begin
      mCnt = 0; mOut = 0; mOutPosted = 0; mInit = 0; mMask = 0;
      expAckValid = 0; expAckCode = 0; expPulse = 0; expStatus = 0;
    end else begin
      hv  = mCnt > 0;
      mmv = hv && !qKill[0] && !mOut && !busReset;
      iss = mmv && memReady;
      pk  = hv && qKill[0];
      acc = reqValid && !busReset;
      code = decide(reqType, reqSrc, reqOffset, tag);
      pulse = memDoneValid && memDoneErr && mOut && mOutPosted;
      expIntrTag = pulse ? "R9" : ((memDoneValid && mOut && !mOutPosted) ? "R10" :
                   (intrClr ? "R11" : "R9"));
      expPulse  = pulse;
      expStatus = (expStatus && !intrClr) || pulse;
      if (iss) begin mOut = 1; mOutPosted = qPost[0]; end
      else if (memDoneValid) mOut = 0;
      if (iss || pk) begin
        for (int i = 0; i < DEPTH - 1; i++) begin
          qBody[i] = qBody[i+1]; qPost[i] = qPost[i+1]; qKill[i] = qKill[i+1];
        end
        mCnt--;
      end
      if (acc && (code == 2'd0 || code == 2'd1)) begin
        qBody[mCnt] = {reqType, reqSrc, reqOffset, reqTag, reqSpeed};
        qPost[mCnt] = (reqType == 2'd1); qKill[mCnt] = 0;
        mCnt++;
      end
      if (busReset) begin
        for (int i = 0; i < DEPTH; i++) if (i < mCnt && !qPost[i]) qKill[i] = 1;
        mInit = 0;
      end else if (filterWrEn) begin
        mInit = 1; mMask = filterWrData;
      end
      expAckValid = acc; expAckCode = code; expAckTag = tag;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit mmv = (mCnt > 0) && !qKill[0] && !mOut && !busReset;
    bit anyKill = 0;
    for (int i = 0; i < DEPTH; i++) if (i < mCnt && qKill[i]) anyKill = 1;
    chk("R1", reqReady, !busReset);
    chk(expAckTag, ackValid, expAckValid);
    if (expAckValid) chk(expAckTag, ackCode, expAckCode);
    chk(anyKill ? "R7" : "R8", memValid, mmv);
    if (mmv) chk("R8", {memType, memSrc, memOffset, memTag, memSpeed}, qBody[0]);
    chk(expIntrTag, intrPulse, expPulse);
    chk(expIntrTag, intrStatus, expStatus);
  endtask

  int memMode = 0;  // 0 stalled, 1 prompt, 2 random
  bit errMode = 0;

  task automatic driveMem();
    case (memMode)
      0: begin memReady = 0; memDoneValid = 0; memDoneErr = 0; end
      1: begin memReady = 1; memDoneValid = mOut; memDoneErr = errMode; end
      default: begin
        memReady = $urandom_range(1, 0);
        memDoneValid = mOut && ($urandom_range(2, 0) == 0);
        memDoneErr = $urandom_range(1, 0);
      end
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    driveMem();
  endtask

  task automatic sendReq(input logic [1:0] t, input logic [5:0] s, input logic [15:0] o);
    reqValid = 1; reqType = t; reqSrc = s; reqOffset = o;
    reqTag = reqTag + 1; reqSpeed = reqSpeed + 1;
    step();
    reqValid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", ackValid, 0); chk("R12", memValid, 0);
    chk("R12", intrPulse, 0); chk("R12", intrStatus, 0);
    sendReq(2'd0, 6'd5, 16'h1000);          // R5/R12 filters not ready -> busy
    sendReq(2'd0, 6'd5, 16'hF004);          // R5 CSR read admitted
    sendReq(2'd1, 6'd9, 16'hF100);          // R2 posted CSR write
    filterWrEn = 1; filterWrData = 64'h20; step(); filterWrEn = 0;
    sendReq(2'd0, 6'd6, 16'h2000);          // R6 masked source
    sendReq(2'd3, 6'd5, 16'h2000);          // R3 lock
    sendReq(2'd2, 6'd5, 16'h3000);          // R3 non-posted write, queue full
    sendReq(2'd1, 6'd5, 16'h3004);          // R4 busy when full
    busReset = 1; sendReq(2'd0, 6'd5, 16'hF000); busReset = 0;  // R1, R7
    idle(3);
    memMode = 1; errMode = 1; idle(8);      // R9 posted error
    sendReq(2'd0, 6'd5, 16'h2000);          // R5 filters dropped by bus reset
    filterWrEn = 1; filterWrData = '1; step(); filterWrEn = 0;
    sendReq(2'd0, 6'd1, 16'h0040); idle(4); // R10 read error, no interrupt
    intrClr = 1; step(); intrClr = 0; idle(2); // R11
    sendReq(2'd1, 6'd2, 16'h0080);
    intrClr = 1; idle(4); intrClr = 0; idle(2); // R11 set vs clear
    memMode = 2;
    for (int c = 0; c < 5000; c++) begin
      reqValid = ($urandom_range(1, 0) == 1);
      reqType = 2'($urandom_range(3, 0)); reqSrc = 6'($urandom_range(63, 0));
      reqOffset = ($urandom_range(3, 0) == 0) ? 16'($urandom_range(16'hF3FF, 16'hF000))
                                              : 16'($urandom_range(16'hFFFF, 0));
      reqTag = 6'($urandom_range(63, 0)); reqSpeed = 2'($urandom_range(3, 0));
      busReset = ($urandom_range(199, 0) == 0);
      filterWrEn = ($urandom_range(79, 0) == 0);
      filterWrData = {32'($urandom()), 32'($urandom())} | 64'hF0F0_F0F0_F0F0_F0F0;
      intrClr = ($urandom_range(39, 0) == 0);
      step();
    end
    reqValid = 0; busReset = 0; filterWrEn = 0; intrClr = 0;
    idle(10);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule